// File: doc/BRIEF.md
# Circular Trace Buffer Address Sequencer

The block sits between a trace encoder and a memory write port. Encoder words enter a small internal FIFO. The sequencer drains the FIFO into a memory window that software places between a start address and an end address. Each word that memory accepts is written at the current address, and the pointer then moves on by one word. When the word that covers the end of the window has been written, the pointer either returns to the start (wrap mode) or stops and blocks further writes (stop mode). A write-one strobe returns the pointer to the start and releases a stopped sequencer.

Two events can raise the interrupt line. The first is an encoder word that is dropped because the FIFO is full. The second is a buffer-full condition, meaning a wrap or a stop. Each event has its own enable bit, sticky raw bit and write-one-to-clear bit. A simple register port (write strobe, 4-bit select, 32-bit write data, combinational read data) gives access to the window, the pointer, the strobes, the status and the interrupt set.

The control state machine has two states. ST_RUN presents the FIFO head to memory whenever the FIFO holds a word. ST_STOP holds the memory port idle. The transition ST_RUN to ST_STOP happens when the last word of the window is accepted in stop mode. The transition ST_STOP to ST_RUN happens on a rewind strobe. A rewind in ST_RUN keeps the state and only reloads the pointer.

Top module: `trace_ring_seq`

## Requirements
- R1: After reset the start register reads 0 and the end register reads 0xFFFFFFFF. The current address reads 0 and the loop bit (select 8, bit 0) reads 1. Status (select 4) reads 1, which means bit 0 (FIFO empty) is set. Raw (select 6) reads 0 and irq is low.
- R2: While mem_valid is high, mem_addr equals the current address (select 2) and mem_data is the oldest word in the FIFO, in arrival order. Each cycle with mem_valid and mem_ready both high pops that word and adds 4 to the current address, unless R3, R4 or R5 applies. Without a handshake or rewind, the current address holds.
- R3: A word is the last word of the window when its address plus 4 exceeds the end address, compared unsigned in 33 bits. When a last word is accepted in loop mode, the current address becomes the start address and raw bit 1 (buffer full) is set.
- R4: When a last word is accepted with the loop bit at 0, raw bit 1 is set, the current address stays at that word's address, status bit 2 (stopped) is set and mem_valid stays low until a rewind.
- R5: Writing select 3 with bit 0 set loads the current address with the start address and clears the stopped condition. This takes priority over a concurrent advance. Select 3 always reads 0.
- R6: The FIFO holds DEPTH words (default 4). An encoder push while the FIFO is full is dropped, even in a cycle that pops, and it sets raw bit 0 (overflow).
- R7: Raw bits stay set until a write of 1 to the matching bit of select 7. A new event in the same cycle as a clear leaves the bit set. Select 7 reads 0.
- R8: irq is high exactly when some raw bit is set and its enable bit (select 5, bits 1:0) is set.
- R9: Status bit 0 is FIFO empty, bit 1 is FIFO full and bit 2 is stopped. mem_valid is low whenever the FIFO is empty.
- R10: Start (select 0), end (select 1), enable (select 5) and loop (select 8) read back the last value written. Unmapped selects read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_valid | input | 1 | Encoder word push |
| enc_data | input | 32 | Encoder word |
| mem_valid | output | 1 | Write request to memory |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | 32 | Write address |
| mem_data | output | 32 | Write data |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 4 | Register select for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_sel |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted pointer shows on mem_addr at the next handshake and on select 2 at once. A wrong last-word decision appears one cycle after the end word is accepted: the pointer continues past the window, mem_valid goes low where it should not, or raw bit 1 does not set. A FIFO ordering or count error shows on mem_data, or on the empty and full flags, within DEPTH pops. A wrong sticky or set-wins decision shows on irq and select 6 on the cycle after the event. The reference model compares every output on every cycle, so a divergence is reported in the cycle it first becomes visible.

// File: rtl/trace_ring_pkg.sv
package trace_ring_pkg;
    localparam int SEL_W = 4;

    localparam logic [SEL_W-1:0] SEL_START  = 4'd0;
    localparam logic [SEL_W-1:0] SEL_END    = 4'd1;
    localparam logic [SEL_W-1:0] SEL_CUR    = 4'd2;
    localparam logic [SEL_W-1:0] SEL_REWIND = 4'd3;
    localparam logic [SEL_W-1:0] SEL_STATUS = 4'd4;
    localparam logic [SEL_W-1:0] SEL_IEN    = 4'd5;
    localparam logic [SEL_W-1:0] SEL_IRAW   = 4'd6;
    localparam logic [SEL_W-1:0] SEL_ICLR   = 4'd7;
    localparam logic [SEL_W-1:0] SEL_CTRL   = 4'd8;

    localparam int NUM_IRQ = 2;
    localparam int IRQ_OVF  = 0;
    localparam int IRQ_FULL = 1;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_STOP = 1'b1
    } seq_state_t;
endpackage

// File: rtl/trace_ring_fifo.sv
module trace_ring_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_req,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic          empty,
    output logic          full,
    output logic          overflow
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [DW-1:0] store [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign empty    = (count == '0);
    assign full     = (count == FULL_CNT);
    assign overflow = push_req && full;
    assign do_push  = push_req && !full;
    assign do_pop   = pop && !empty;
    assign head     = store[rd_ptr];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
            end
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            store[wr_ptr] <= push_data;
        end
    end
endmodule

// File: rtl/trace_ring_addr.sv
module trace_ring_addr
    import trace_ring_pkg::*;
#(
    parameter int AW   = 32,
    parameter int STEP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] win_start,
    input  logic [AW-1:0] win_end,
    input  logic          loop_mode,
    input  logic          rewind,
    input  logic          fifo_empty,
    input  logic          mem_ready,
    output logic [AW-1:0] cur_addr,
    output logic          mem_valid,
    output logic          pop,
    output logic          full_evt,
    output logic          stopped
);
    seq_state_t    state_q, state_d;
    logic [AW-1:0] cur_d;
    logic          is_last;

    assign is_last = ({1'b0, cur_addr} + (AW+1)'(STEP)) > {1'b0, win_end};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_RUN;
            cur_addr <= '0;
        end else begin
            state_q  <= state_d;
            cur_addr <= cur_d;
        end
    end

    always_comb begin
        state_d   = state_q;
        cur_d     = cur_addr;
        mem_valid = 1'b0;
        pop       = 1'b0;
        full_evt  = 1'b0;
        stopped   = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                mem_valid = !fifo_empty;
                pop       = mem_valid && mem_ready;
                if (pop) begin
                    if (is_last) begin
                        full_evt = 1'b1;
                        if (loop_mode) begin
                            cur_d = win_start;
                        end else begin
                            state_d = ST_STOP;
                        end
                    end else begin
                        cur_d = cur_addr + AW'(STEP);
                    end
                end
            end
            ST_STOP: begin
                stopped = 1'b1;
            end
            default: begin
                state_d = ST_RUN;
            end
        endcase
        if (rewind) begin
            cur_d   = win_start;
            state_d = ST_RUN;
        end
    end
endmodule

// File: rtl/trace_ring_irq.sv
module trace_ring_irq #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] en,
    output logic [N-1:0] raw,
    output logic         irq
);
    for (genvar i = 0; i < N; i++) begin : g_src
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                raw[i] <= 1'b0;
            end else if (set[i]) begin
                raw[i] <= 1'b1;
            end else if (clr[i]) begin
                raw[i] <= 1'b0;
            end
        end
    end

    assign irq = |(raw & en);
endmodule

// File: rtl/trace_ring_seq.sv
module trace_ring_seq
    import trace_ring_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enc_valid,
    input  logic [DW-1:0]    enc_data,
    output logic             mem_valid,
    input  logic             mem_ready,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_data,
    input  logic             reg_we,
    input  logic [SEL_W-1:0] reg_sel,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             irq
);
    localparam int STEP = DW / 8;

    logic [AW-1:0]      start_q, end_q, cur_addr;
    logic [NUM_IRQ-1:0] en_q, raw_q, irq_set, irq_clr;
    logic               loop_q;
    logic               rewind, pop, full_evt, stopped;
    logic               fifo_empty, fifo_full, fifo_ovf;

    assign rewind  = reg_we && (reg_sel == SEL_REWIND) && reg_wdata[0];
    assign irq_clr = (reg_we && (reg_sel == SEL_ICLR)) ? reg_wdata[NUM_IRQ-1:0] : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            end_q   <= '1;
            en_q    <= '0;
            loop_q  <= 1'b1;
        end else if (reg_we) begin
            unique case (reg_sel)
                SEL_START: start_q <= reg_wdata[AW-1:0];
                SEL_END:   end_q   <= reg_wdata[AW-1:0];
                SEL_IEN:   en_q    <= reg_wdata[NUM_IRQ-1:0];
                SEL_CTRL:  loop_q  <= reg_wdata[0];
                default:   ;
            endcase
        end
    end

    trace_ring_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_req  (enc_valid),
        .push_data (enc_data),
        .pop       (pop),
        .head      (mem_data),
        .empty     (fifo_empty),
        .full      (fifo_full),
        .overflow  (fifo_ovf)
    );

    trace_ring_addr #(.AW(AW), .STEP(STEP)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .win_start  (start_q),
        .win_end    (end_q),
        .loop_mode  (loop_q),
        .rewind     (rewind),
        .fifo_empty (fifo_empty),
        .mem_ready  (mem_ready),
        .cur_addr   (cur_addr),
        .mem_valid  (mem_valid),
        .pop        (pop),
        .full_evt   (full_evt),
        .stopped    (stopped)
    );

    always_comb begin
        irq_set           = '0;
        irq_set[IRQ_OVF]  = fifo_ovf;
        irq_set[IRQ_FULL] = full_evt;
    end

    trace_ring_irq #(.N(NUM_IRQ)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (irq_set),
        .clr   (irq_clr),
        .en    (en_q),
        .raw   (raw_q),
        .irq   (irq)
    );

    assign mem_addr = cur_addr;

    always_comb begin
        reg_rdata = '0;
        unique case (reg_sel)
            SEL_START:  reg_rdata[AW-1:0]      = start_q;
            SEL_END:    reg_rdata[AW-1:0]      = end_q;
            SEL_CUR:    reg_rdata[AW-1:0]      = cur_addr;
            SEL_STATUS: reg_rdata[2:0]         = {stopped, fifo_full, fifo_empty};
            SEL_IEN:    reg_rdata[NUM_IRQ-1:0] = en_q;
            SEL_IRAW:   reg_rdata[NUM_IRQ-1:0] = raw_q;
            SEL_CTRL:   reg_rdata[0]           = loop_q;
            default:    reg_rdata              = '0;
        endcase
    end
endmodule

// File: rtl/trace_ring_chk.sv
module trace_ring_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          enc_valid,
    input logic          mem_valid,
    input logic          mem_ready,
    input logic          irq,
    input logic          rewind,
    input logic          fifo_full,
    input logic          fifo_empty,
    input logic          stopped,
    input logic [AW-1:0] cur_addr,
    input logic [AW-1:0] start_q,
    input logic [1:0]    raw_q,
    input logic [1:0]    en_q
);
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!(mem_valid && mem_ready) && !rewind) |=> $stable(cur_addr));

    p_stop_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stopped |-> !mem_valid);

    p_rewind_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rewind |=> (cur_addr == $past(start_q)));

    p_ovf_raw_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_valid && fifo_full) |=> raw_q[0]);

    p_irq_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == 2'b00) |-> !irq);

    p_empty_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_empty |-> !mem_valid);
endmodule

bind trace_ring_seq trace_ring_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enc_valid  (enc_valid),
    .mem_valid  (mem_valid),
    .mem_ready  (mem_ready),
    .irq        (irq),
    .rewind     (rewind),
    .fifo_full  (fifo_full),
    .fifo_empty (fifo_empty),
    .stopped    (stopped),
    .cur_addr   (cur_addr),
    .start_q    (start_q),
    .raw_q      (raw_q),
    .en_q       (en_q)
);

// File: tb/test_trace_ring_seq.sv
module test_trace_ring_seq;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enc_valid = 1'b0;
    logic [31:0] enc_data = '0;
    logic        mem_valid;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_addr, mem_data;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    trace_ring_seq #(.AW(32), .DW(32), .DEPTH(DEPTH)) i_trace_ring_seq (
        .clk(clk), .rst_n(rst_n), .enc_valid(enc_valid), .enc_data(enc_data),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
        .mem_data(mem_data), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    // behavioural reference state
    logic [31:0] m_start = 32'h0;
    logic [31:0] m_end   = 32'hFFFF_FFFF;
    logic [31:0] m_cur   = 32'h0;
    logic        m_loop  = 1'b1;
    logic        m_halt  = 1'b0;
    logic [1:0]  m_en    = 2'b00;
    logic [1:0]  m_raw   = 2'b00;
    logic [31:0] q[$];

    task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string tag_for(input logic [3:0] s);
        case (s)
            4'd2:       return "R2 current address";
            4'd3:       return "R5 rewind reads zero";
            4'd4:       return "R9 status";
            4'd6, 4'd7: return "R7 raw/clear readback";
            default:    return "R10 register readback";
        endcase
    endfunction

    function automatic logic [31:0] exp_rdata(input logic [3:0] s);
        case (s)
            4'd0: return m_start;
            4'd1: return m_end;
            4'd2: return m_cur;
            4'd4: return {29'b0, m_halt, (q.size() == DEPTH), (q.size() == 0)};
            4'd5: return {30'b0, m_en};
            4'd6: return {30'b0, m_raw};
            4'd8: return {31'b0, m_loop};
            default: return 32'h0;
        endcase
    endfunction

    // one clock: drive, compare all outputs, advance the model
    task automatic cyc(input logic we, input logic [3:0] sel, input logic [31:0] wd,
                       input logic ev, input logic [31:0] ed, input logic rdy,
                       input string tag = "");
        logic        exp_v, hs, ovf, fev, nhalt;
        logic [31:0] ncur;
        logic [1:0]  clr;
        @(negedge clk);
        reg_we = we; reg_sel = sel; reg_wdata = wd;
        enc_valid = ev; enc_data = ed; mem_ready = rdy;
        #1;
        exp_v = !m_halt && (q.size() > 0);
        cmp("R2 mem_valid", {31'b0, mem_valid}, {31'b0, exp_v});
        if (exp_v) begin
            cmp("R2 mem_addr", mem_addr, m_cur);
            cmp("R2 mem_data", mem_data, q[0]);
        end
        cmp("R8 irq", {31'b0, irq}, {31'b0, |(m_raw & m_en)});
        cmp((tag == "") ? tag_for(sel) : tag, reg_rdata, exp_rdata(sel));

        hs = exp_v && rdy;
        ovf = ev && (q.size() == DEPTH);
        fev = 1'b0;
        ncur = m_cur;
        nhalt = m_halt;
        if (hs) begin
            void'(q.pop_front());
            if (({1'b0, m_cur} + 33'd4) > {1'b0, m_end}) begin
                fev = 1'b1;
                if (m_loop) ncur = m_start;
                else        nhalt = 1'b1;
            end else begin
                ncur = m_cur + 32'd4;
            end
        end
        if (ev && !ovf) q.push_back(ed);
        if (we && sel == 4'd3 && wd[0]) begin
            ncur = m_start;
            nhalt = 1'b0;
        end
        clr = (we && sel == 4'd7) ? wd[1:0] : 2'b00;
        m_raw = (m_raw & ~clr) | {fev, ovf};
        if (we) begin
            case (sel)
                4'd0: m_start = wd;
                4'd1: m_end = wd;
                4'd5: m_en = wd[1:0];
                4'd8: m_loop = wd[0];
                default: ;
            endcase
        end
        m_cur = ncur;
        m_halt = nhalt;
    endtask

    task automatic wr(input logic [3:0] sel, input logic [31:0] wd);
        cyc(1'b1, sel, wd, 1'b0, 32'h0, 1'b0);
    endtask

    task automatic idle(input logic [3:0] sel, input string tag);
        cyc(1'b0, sel, 32'h0, 1'b0, 32'h0, 1'b0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values on every register
        for (int s = 0; s < 10; s++) idle(4'(s), "R1 reset value");

        // R3: loop-mode wrap in a 4-word window
        wr(4'd0, 32'h0000_0100);
        wr(4'd1, 32'h0000_010F);
        wr(4'd5, 32'h0000_0003);
        wr(4'd3, 32'h0000_0001);
        for (int i = 0; i < 10; i++)
            cyc(1'b0, 4'd2, 32'h0, 1'b1, 32'hA000_0000 + 32'(i), 1'b1, "R3 wrap address");
        for (int i = 0; i < 4; i++) cyc(1'b0, 4'd6, 32'h0, 1'b0, 32'h0, 1'b1, "R3 full raw");

        // R7: clear, and a clear that coincides with a new overflow event
        wr(4'd7, 32'h3);
        idle(4'd6, "R7 cleared");

        // R6: overflow with memory stalled
        for (int i = 0; i < 7; i++)
            cyc(1'b0, 4'd4, 32'h0, 1'b1, 32'hB000_0000 + 32'(i), 1'b0, "R6 overflow status");
        idle(4'd6, "R6 overflow raw");
        cyc(1'b1, 4'd7, 32'h1, 1'b1, 32'hC0DE, 1'b0, "R7 set wins");
        idle(4'd6, "R7 set wins raw");
        wr(4'd7, 32'h3);

        // R4: stop mode
        wr(4'd8, 32'h0);
        wr(4'd3, 32'h1);
        for (int i = 0; i < 12; i++)
            cyc(1'b0, 4'd4, 32'h0, 1'b1, 32'hD000_0000 + 32'(i), 1'b1, "R4 stop status");
        idle(4'd2, "R4 stopped address");
        // R5: rewind releases the stop
        cyc(1'b1, 4'd3, 32'h1, 1'b0, 32'h0, 1'b1, "R5 rewind reads zero");
        for (int i = 0; i < 4; i++) cyc(1'b0, 4'd2, 32'h0, 1'b0, 32'h0, 1'b1, "R5 resumed");

        // random traffic with occasional register activity
        for (int i = 0; i < 4000; i++) begin
            logic        we;
            logic [3:0]  sel;
            logic [31:0] wd;
            int          r;
            r = $urandom_range(0, 99);
            we = (r < 8);
            sel = 4'($urandom_range(0, 9));
            wd = $urandom;
            if (we && sel == 4'd0) wd = 32'h200 + 32'($urandom_range(0, 8)) * 4;
            if (we && sel == 4'd1) wd = 32'h200 + 32'($urandom_range(0, 40));
            cyc(we, sel, wd, ($urandom_range(0, 2) != 0), $urandom, ($urandom_range(0, 3) != 0));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule